// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Atomic Mask Ports

This block gathers 32 level-sensitive interrupt request lines into one interrupt output toward the processor. Each request line is brought into the local clock domain through a two-flop synchronizer, and the synchronized value is readable as the raw status word. A per-source mask, where a 1 blocks the source and a 0 enables it, decides which asserted sources count as pending. The single output is high whenever any source is pending.

Software never writes the mask directly. It writes a word to a set port, and every 1 in that word blocks the matching source, or it writes to a clear port, and every 1 enables the matching source. Zero bits leave the mask unchanged in both cases. Two drivers can therefore change separate sources without a read-modify-write. To make dispatch faster, a read-only word reports whether anything is pending and gives the index of the highest-numbered pending source, which has the highest priority.

Accesses use a simple single-cycle bus. Read data is a combinational function of the address and the registered state. A write takes effect at the rising clock edge where it is presented.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: On synchronous reset the mask is all ones, so the mask word (offset 0x04) reads 0xFFFFFFFF and `irq_o` is low whatever the sources are doing.
- R2: A change on a source line appears in the status word (offset 0x00) and on `irq_o` after exactly two rising clock edges. It is not yet visible after one edge.
- R3: A write to offset 0x08 sets to 1 the mask bit of every source whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A write to offset 0x0C clears to 0 the mask bit of every source whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: The pending word (offset 0x10) equals the status word AND the inverted mask, and `irq_o` is 1 exactly when the pending word is nonzero.
- R6: Pending is a level. It stays set while the source is high and unmasked, reads have no side effect, no acknowledge exists, and it drops once the synchronized source goes low.
- R7: Offset 0x14 returns bit 31 = 1 and bits 4:0 = index of the highest-numbered pending source, with all other bits 0. When nothing is pending it returns 0.
- R8: Reads of any other address, including unaligned ones, return 0. Writes to offsets 0x00, 0x04, 0x10, 0x14 or any undecoded address leave the mask unchanged.
- R9: One write of 0xFFFFFFFF to offset 0x08 blocks all 32 sources, and `irq_o` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Level-sensitive request lines, one per source |
| bus_wr | input | 1 | Write strobe; the write happens at this rising edge |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt toward the processor |

## Verification
On every cycle, the checker confirms several behaviours. Set and clear writes change only the bits that carry a 1. Writes to read-only or undecoded addresses and bus idle cycles leave the mask untouched. The output agrees with the status and the mask. Whenever the index word is read, it names exactly the top pending bit. The bench scenarios cover the rest: the two-edge latency of the synchronizer, the reset value of the mask after traffic, reads that do not clear anything, and the exact read values at each offset under several source and mask patterns.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int NUM_SRC = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int SYNC_STAGES = 2;
    localparam int IDX_W   = $clog2(NUM_SRC);

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SETM   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLRM   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_TOP    = 8'h14;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_MASK,
        SEL_SETM,
        SEL_CLRM,
        SEL_PEND,
        SEL_TOP,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic               set_en;
        logic               clr_en;
        logic [NUM_SRC-1:0] bits;
    } mask_cmd_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } top_src_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_STATUS: s = SEL_STATUS;
            OFS_MASK:   s = SEL_MASK;
            OFS_SETM:   s = SEL_SETM;
            OFS_CLRM:   s = SEL_CLRM;
            OFS_PEND:   s = SEL_PEND;
            OFS_TOP:    s = SEL_TOP;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_top(input top_src_t t);
        logic [DATA_W-1:0] w;
        w = '0;
        if (t.valid) begin
            w[DATA_W-1]  = 1'b1;
            w[IDX_W-1:0] = t.idx;
        end
        return w;
    endfunction

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_mask.sv
module lvl_irq_mask
    import lvl_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  mask_cmd_t          cmd_i,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (cmd_i.set_en) mask_d = mask_q | cmd_i.bits;
        if (cmd_i.clr_en) mask_d = mask_q & ~cmd_i.bits;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio
    import lvl_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    output top_src_t           top_o
);
    always_comb begin
        top_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i]) begin
                top_o.valid = 1'b1;
                top_o.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_irq_rdmux.sv
module lvl_irq_rdmux
    import lvl_irq_pkg::*;
(
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  top_src_t           top_i,
    output logic [DATA_W-1:0]  rdata_o
);
    always_comb begin
        case (sel_i)
            SEL_STATUS: rdata_o = DATA_W'(status_i);
            SEL_MASK:   rdata_o = DATA_W'(mask_i);
            SEL_PEND:   rdata_o = DATA_W'(pend_i);
            SEL_TOP:    rdata_o = pack_top(top_i);
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend;
    reg_sel_e           sel;
    mask_cmd_t          cmd;
    top_src_t           top;

    lvl_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_src_i),
        .q_o (status_q)
    );

    assign sel = decode_addr(bus_addr);

    always_comb begin
        cmd.set_en = bus_wr && (sel == SEL_SETM);
        cmd.clr_en = bus_wr && (sel == SEL_CLRM);
        cmd.bits   = bus_wdata[NUM_SRC-1:0];
    end

    lvl_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .mask_o (mask_q)
    );

    assign pend  = status_q & ~mask_q;
    assign irq_o = |pend;

    lvl_irq_prio u_prio (
        .pend_i (pend),
        .top_o  (top)
    );

    lvl_irq_rdmux u_rdmux (
        .sel_i    (sel),
        .status_i (status_q),
        .mask_i   (mask_q),
        .pend_i   (pend),
        .top_i    (top),
        .rdata_o  (bus_rdata)
    );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
    import lvl_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] status_q
);
    logic ro_or_undecoded;
    assign ro_or_undecoded = (bus_addr != OFS_SETM) && (bus_addr != OFS_CLRM);

    // R1
    a_r1_reset_mask: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && !irq_o));

    // R3
    a_r3_set_ones: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SETM) |=>
            ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    a_r3_set_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SETM) |=>
            ((mask_q & ~$past(bus_wdata)) == ($past(mask_q) & ~$past(bus_wdata))));

    // R4
    a_r4_clear_ones: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CLRM) |=> ((mask_q & $past(bus_wdata)) == '0));
    a_r4_clear_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CLRM) |=>
            ((mask_q & ~$past(bus_wdata)) == ($past(mask_q) & ~$past(bus_wdata))));

    // R5
    a_r5_irq_matches: assert property (@(posedge clk) disable iff (rst)
        irq_o == ((status_q & ~mask_q) != '0));

    // R6
    a_r6_idle_no_effect: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(mask_q));

    // R7
    a_r7_top_exact: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_TOP && bus_rdata[DATA_W-1]) |->
            (((status_q & ~mask_q) >> bus_rdata[IDX_W-1:0]) == 1));
    a_r7_top_empty: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_TOP && !bus_rdata[DATA_W-1]) |->
            (bus_rdata == '0 && (status_q & ~mask_q) == '0));

    // R8
    a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ro_or_undecoded) |=> $stable(mask_q));

    // R9
    a_r9_mask_all: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SETM && bus_wdata == '1) |=> !irq_o);
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
    import lvl_irq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] irq_src_i = '0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic               irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_src_i (irq_src_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] src;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 32'hFFFF_FFFF, 4'd1}, // R1 mask after reset
        '{1'b0, 8'h10, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd1}, // R1 all blocked
        '{1'b0, 8'h00, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2}, // R2 raw status
        '{1'b1, 8'h0C, 32'h0000_00F0, 32'h0000_0030, 32'h0, 4'd4},
        '{1'b0, 8'h04, 32'h0, 32'h0000_0030, 32'hFFFF_FF0F, 4'd4}, // R4 clear
        '{1'b0, 8'h10, 32'h0, 32'h0000_0030, 32'h0000_0030, 4'd5}, // R5 pending
        '{1'b0, 8'h14, 32'h0, 32'h0000_0030, 32'h8000_0005, 4'd7}, // R7 index 5
        '{1'b1, 8'h08, 32'h0000_0010, 32'h0000_0030, 32'h0, 4'd3},
        '{1'b0, 8'h04, 32'h0, 32'h0000_0030, 32'hFFFF_FF1F, 4'd3}, // R3 set
        '{1'b0, 8'h10, 32'h0, 32'h0000_0030, 32'h0000_0020, 4'd5}, // R5 after set
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0030, 32'h0, 4'd8},
        '{1'b0, 8'h04, 32'h0, 32'h0000_0030, 32'hFFFF_FF1F, 4'd8}, // R8 ro write ignored
        '{1'b0, 8'h18, 32'h0, 32'h0000_0030, 32'h0000_0000, 4'd8}, // R8 undecoded read
        '{1'b1, 8'h0C, 32'h8000_0000, 32'h8000_0030, 32'h0, 4'd4},
        '{1'b0, 8'h14, 32'h0, 32'h8000_0030, 32'h8000_001F, 4'd7}, // R7 top source 31
        '{1'b0, 8'h10, 32'h0, 32'h8000_0030, 32'h8000_0020, 4'd5}, // R5
        '{1'b0, 8'h14, 32'h0, 32'h0000_0000, 32'h0000_0000, 4'd7}  // R7 nothing pending
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1 check(1, {31'b0, irq_o}, 32'h0, "irq low after reset");

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            irq_src_i = VEC[i].src;
            settle();
            if (VEC[i].is_wr) bus_write(VEC[i].addr, VEC[i].data);
            else begin
                bus_read(VEC[i].addr, rd);
                check(int'(VEC[i].req), rd, VEC[i].exp, $sformatf("vector %0d", i));
            end
        end

        // R2: latency of exactly two edges
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'h0000_0001);
        check(2, {31'b0, irq_o}, 32'h0, "irq low before source");
        irq_src_i = 32'h0000_0001;
        @(negedge clk);
        check(2, {31'b0, irq_o}, 32'h0, "not visible after one edge");
        @(negedge clk);
        check(2, {31'b0, irq_o}, 32'h1, "visible after two edges");

        // R6: reads do not acknowledge
        bus_read(8'h10, rd);
        check(6, rd, 32'h1, "pending first read");
        bus_read(8'h10, rd);
        check(6, rd, 32'h1, "pending second read");
        check(6, {31'b0, irq_o}, 32'h1, "irq held while level high");
        irq_src_i = '0;
        settle();
        check(6, {31'b0, irq_o}, 32'h0, "irq drops with level");

        // R9: mask everything in one write
        irq_src_i = 32'hFFFF_FFFF;
        bus_write(8'h0C, 32'hFFFF_FFFF);
        settle();
        check(9, {31'b0, irq_o}, 32'h1, "irq high before mask-all");
        bus_write(8'h08, 32'hFFFF_FFFF);
        check(9, {31'b0, irq_o}, 32'h0, "irq low after mask-all");

        // R8: write to index and pending offsets ignored
        bus_write(8'h14, 32'h0);
        bus_write(8'h10, 32'h0);
        bus_write(8'h0D, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        check(8, rd, 32'hFFFF_FFFF, "mask unchanged by ro writes");
        bus_read(8'h09, rd);
        check(8, rd, 32'h0, "unaligned read zero");

        // R1: reset in the middle of traffic
        bus_write(8'h0C, 32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(8'h04, rd);
        check(1, rd, 32'hFFFF_FFFF, "mask after mid-run reset");
        check(1, {31'b0, irq_o}, 32'h0, "irq after mid-run reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule